// File: doc/BRIEF.md
# Floating-Point Instruction Decoder

This block turns 16-bit floating-point coprocessor instruction words into a decoded operation for an FPU datapath. For each accepted word it yields an operation code, the raw n and m register fields, 5-bit effective FP register selects that already include the bank and pair-extension rules, and a width flag for 64-bit operation. It also yields a transfer-register select for system moves, a T-bit write strobe for compares, a mode-bit flip mask and an illegal-instruction flag. It does not execute anything and does not hold the register file or the status register. The current mode bits (bank, precision, transfer size) come in as plain pins beside the word.

Decoding has two levels. Words with a top nibble of 0xF form the arithmetic group, indexed by the low nibble. One entry of that group reuses the m field as a second index into single-operand operations. The last leaf of that second index turns n into a mode-flip or transform selector. All other words are matched as system-register transfers.

Words enter on a valid/ready input and leave on a valid/ready output through one register stage. The input is ready whenever the stage is empty or the downstream takes the word in that cycle. While the output is valid and not taken, every output holds steady and no new word is accepted. A word accepted at a clock edge shows its decode on the outputs right after that edge.

Top module: `fpu_op_decode`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and in_ready is 1 until a word is accepted.
- R2: in_ready equals (not out_valid) or out_ready. A word taken at an edge shows its decode with out_valid=1 right after that edge. While out_valid=1 and out_ready=0, all outputs stay unchanged.
- R3: For words with bits 15:12 = 0xF, rn = bits 11:8, rm = bits 7:4 and x = bits 3:0. x selects, from 0 to 15: add, sub, mul, div, compare-equal, compare-greater, indexed load, indexed store, indirect load, post-increment load, indirect store, pre-decrement store, register move, single-operand group, multiply-accumulate, illegal.
- R4: When x=13, m selects, from 0 to 15: write FR from transfer register, read FR into transfer register, int-to-float, float-to-int, negate, absolute, square root, reciprocal square root, load 0.0, load 1.0, single-to-double, double-to-single, illegal, illegal, inner product, extended group.
- R5: In the extended group (x=13, m=15), n[1:0]=3 gives the mode-flip operation. Its mode_flip mask has one bit set, picked by n[3:2]: 0 sets bit 20 (size), 1 sets bit 19 (precision), 2 sets bit 21 (bank), and 3 gives an all-zero mask. n[1:0]=1 gives matrix transform, and any other value gives sine/cosine. Every other operation drives an all-zero mask.
- R6: Other words are matched on bits 15:12 together with bits 7:0. 0x0_5A and 0x0_6A read the system register into Rn. 0x4_5A and 0x4_6A write it from Rn. 0x4_52 and 0x4_62 are pre-decrement stores. 0x4_56 and 0x4_66 are post-increment loads. xr_sel equals bit 4 of the word for these words (1 = transfer register, 0 = status register).
- R7: x=15, single-operand m=12 or m=13, and any unmatched non-0xF word set illegal=1 with op = NOP. In that case tbit_we, wide, xr_sel and mode_flip are all 0.
- R8: tbit_we=1 only for compare-equal (x=4) and compare-greater (x=5). tbit_gt=1 only for compare-greater.
- R9: wide equals mode_prec for x=0..5, int-to-float and float-to-int. It equals mode_size for x=6..12. It is 0 for every other operation.
- R10: fn_sel and fm_sel are {bank, field}. For a move under mode_size=1, an odd field is replaced by {field[3:1],0} and the bank bit is inverted. The rule applies to the n field of loads (x=6,8,9), to the m field of stores (x=7,10,11), and to both fields of x=12.
- R11: rn and rm always carry bits 11:8 and 7:4 of the accepted word, in every group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 16 | Instruction word |
| mode_size | input | 1 | Current transfer-size mode bit |
| mode_prec | input | 1 | Current precision mode bit |
| mode_bank | input | 1 | Current register-bank mode bit |
| out_valid | output | 1 | Decoded result valid |
| out_ready | input | 1 | Downstream takes the result |
| op | output | 6 | Operation code (package enumeration) |
| rn | output | 4 | Raw n field |
| rm | output | 4 | Raw m field |
| fn_sel | output | 5 | Effective FP register select for n |
| fm_sel | output | 5 | Effective FP register select for m |
| wide | output | 1 | Operation works on 64-bit values |
| xr_sel | output | 1 | System move uses transfer register (1) or status register (0) |
| tbit_we | output | 1 | Write the T bit from a compare |
| tbit_gt | output | 1 | Compare is greater-than (else equality) |
| mode_flip | output | 22 | XOR mask for the status register |
| illegal | output | 1 | Word is not a legal instruction |

## Verification
The bench builds the decoder with its default parameters: a 22-bit mode mask with the size, precision and bank bits at 20, 19 and 21. Because these positions are distinct, each flip selector shows up as a separate observable bit, and a wrong or swapped selector is caught. The vector table covers every x, every single-operand m, every extended-group n class and each system pattern in both transfer-register choices. It also runs the moves with odd and even fields under each mode combination. Directed steps cover the reset state and a stalled output that must hold while a second word waits.

// File: rtl/fpu_dec_pkg.sv
package fpu_dec_pkg;

  localparam int WORD_W = 16;
  localparam int FLD_W  = 4;
  localparam int IDX_W  = FLD_W + 1;
  localparam int OP_W   = 6;

  typedef enum logic [OP_W-1:0] {
    OP_NOP, OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_CMP_EQ, OP_CMP_GT,
    OP_LD_IDX, OP_ST_IDX, OP_LD_IND, OP_LD_INC, OP_ST_IND, OP_ST_DEC,
    OP_MOV_RR, OP_MAC,
    OP_FROM_XR, OP_TO_XR, OP_ITOF, OP_FTOI, OP_NEG, OP_ABS, OP_SQRT,
    OP_RSQRT, OP_LD_ZERO, OP_LD_ONE, OP_S2D, OP_D2S, OP_IPROD,
    OP_MODE_FLIP, OP_MTRANS, OP_SINCOS,
    OP_SYS_TO_R, OP_R_TO_SYS, OP_SYS_ST_DEC, OP_SYS_LD_INC
  } op_e;

  typedef enum logic [1:0] {
    FLIP_SIZE = 2'd0,
    FLIP_PREC = 2'd1,
    FLIP_BANK = 2'd2,
    FLIP_NONE = 2'd3
  } flip_e;

  typedef struct packed {
    op_e   op;
    logic  ill;
    logic  ext_n;     // n field follows pair-extension rule
    logic  ext_m;     // m field follows pair-extension rule
    logic  prec_dep;  // width follows precision bit
    logic  size_dep;  // width follows transfer-size bit
    logic  flip_en;
    flip_e flip_sel;
    logic  xr_sel;
    logic  tbit_we;
    logic  tbit_gt;
  } dec_t;

  function automatic dec_t dec_blank();
    dec_t d;
    d          = '0;
    d.op       = OP_NOP;
    d.flip_sel = FLIP_NONE;
    return d;
  endfunction

  function automatic dec_t dec_illegal();
    dec_t d;
    d     = dec_blank();
    d.ill = 1'b1;
    return d;
  endfunction

endpackage

// File: rtl/fpdec_unary.sv
module fpdec_unary
  import fpu_dec_pkg::*;
(
  input  logic [FLD_W-1:0] fld_n,
  input  logic [FLD_W-1:0] fld_m,
  output dec_t             dec
);

  always_comb begin
    dec = dec_blank();
    unique case (fld_m)
      4'h0: dec.op = OP_FROM_XR;
      4'h1: dec.op = OP_TO_XR;
      4'h2: begin dec.op = OP_ITOF; dec.prec_dep = 1'b1; end
      4'h3: begin dec.op = OP_FTOI; dec.prec_dep = 1'b1; end
      4'h4: dec.op = OP_NEG;
      4'h5: dec.op = OP_ABS;
      4'h6: dec.op = OP_SQRT;
      4'h7: dec.op = OP_RSQRT;
      4'h8: dec.op = OP_LD_ZERO;
      4'h9: dec.op = OP_LD_ONE;
      4'hA: dec.op = OP_S2D;
      4'hB: dec.op = OP_D2S;
      4'hE: dec.op = OP_IPROD;
      4'hF: begin
        // extended leaf: n picks flip, transform or sine/cosine
        if (fld_n[1:0] == 2'b11) begin
          dec.op       = OP_MODE_FLIP;
          dec.flip_sel = flip_e'(fld_n[3:2]);
          dec.flip_en  = (fld_n[3:2] != 2'b11);
        end else if (fld_n[1:0] == 2'b01) begin
          dec.op = OP_MTRANS;
        end else begin
          dec.op = OP_SINCOS;
        end
      end
      default: dec = dec_illegal();
    endcase
  end

endmodule

// File: rtl/fpdec_arith.sv
module fpdec_arith
  import fpu_dec_pkg::*;
(
  input  logic [FLD_W-1:0] fld_n,
  input  logic [FLD_W-1:0] fld_m,
  input  logic [FLD_W-1:0] fld_x,
  output dec_t             dec
);

  dec_t dec_un;

  fpdec_unary u_unary (
    .fld_n (fld_n),
    .fld_m (fld_m),
    .dec   (dec_un)
  );

  always_comb begin
    dec = dec_blank();
    unique case (fld_x)
      4'h0: begin dec.op = OP_ADD; dec.prec_dep = 1'b1; end
      4'h1: begin dec.op = OP_SUB; dec.prec_dep = 1'b1; end
      4'h2: begin dec.op = OP_MUL; dec.prec_dep = 1'b1; end
      4'h3: begin dec.op = OP_DIV; dec.prec_dep = 1'b1; end
      4'h4: begin
        dec.op = OP_CMP_EQ; dec.prec_dep = 1'b1; dec.tbit_we = 1'b1;
      end
      4'h5: begin
        dec.op = OP_CMP_GT; dec.prec_dep = 1'b1; dec.tbit_we = 1'b1;
        dec.tbit_gt = 1'b1;
      end
      4'h6: begin dec.op = OP_LD_IDX; dec.size_dep = 1'b1; dec.ext_n = 1'b1; end
      4'h7: begin dec.op = OP_ST_IDX; dec.size_dep = 1'b1; dec.ext_m = 1'b1; end
      4'h8: begin dec.op = OP_LD_IND; dec.size_dep = 1'b1; dec.ext_n = 1'b1; end
      4'h9: begin dec.op = OP_LD_INC; dec.size_dep = 1'b1; dec.ext_n = 1'b1; end
      4'hA: begin dec.op = OP_ST_IND; dec.size_dep = 1'b1; dec.ext_m = 1'b1; end
      4'hB: begin dec.op = OP_ST_DEC; dec.size_dep = 1'b1; dec.ext_m = 1'b1; end
      4'hC: begin
        dec.op = OP_MOV_RR; dec.size_dep = 1'b1;
        dec.ext_n = 1'b1; dec.ext_m = 1'b1;
      end
      4'hD: dec = dec_un;
      4'hE: dec.op = OP_MAC;
      default: dec = dec_illegal();
    endcase
  end

endmodule

// File: rtl/fpdec_sys.sv
module fpdec_sys
  import fpu_dec_pkg::*;
(
  input  logic [FLD_W-1:0]   hi_nib,
  input  logic [2*FLD_W-1:0] lo_byte,
  output dec_t               dec
);

  always_comb begin
    dec = dec_blank();
    unique case ({hi_nib, lo_byte})
      12'h05A, 12'h06A: dec.op = OP_SYS_TO_R;
      12'h45A, 12'h46A: dec.op = OP_R_TO_SYS;
      12'h452, 12'h462: dec.op = OP_SYS_ST_DEC;
      12'h456, 12'h466: dec.op = OP_SYS_LD_INC;
      default:          dec.ill = 1'b1;
    endcase
    if (!dec.ill) dec.xr_sel = lo_byte[4];
  end

endmodule

// File: rtl/fpdec_index.sv
module fpdec_index
  import fpu_dec_pkg::*;
(
  input  logic [FLD_W-1:0] fld,
  input  logic             bank,
  input  logic             pair_ext,
  output logic [IDX_W-1:0] eff
);

  logic odd_ext;

  assign odd_ext = pair_ext & fld[0];
  assign eff     = {bank ^ odd_ext, fld[FLD_W-1:1], fld[0] & ~pair_ext};

endmodule

// File: rtl/fpu_op_decode.sv
module fpu_op_decode
  import fpu_dec_pkg::*;
#(
  parameter int MODE_W   = 22,
  parameter int SIZE_POS = 20,
  parameter int PREC_POS = 19,
  parameter int BANK_POS = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              mode_size,
  input  logic              mode_prec,
  input  logic              mode_bank,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OP_W-1:0]   op,
  output logic [FLD_W-1:0]  rn,
  output logic [FLD_W-1:0]  rm,
  output logic [IDX_W-1:0]  fn_sel,
  output logic [IDX_W-1:0]  fm_sel,
  output logic              wide,
  output logic              xr_sel,
  output logic              tbit_we,
  output logic              tbit_gt,
  output logic [MODE_W-1:0] mode_flip,
  output logic              illegal
);

  localparam int NUM_FLD = 2;

  logic [FLD_W-1:0] fld_n, fld_m, fld_x, fld_top;
  logic             is_arith;
  dec_t             dec_a, dec_s, dec_c;
  logic             wide_c;
  logic [MODE_W-1:0] flip_c;
  logic [FLD_W-1:0] fld_arr [NUM_FLD];
  logic             ext_arr [NUM_FLD];
  logic [IDX_W-1:0] eff_arr [NUM_FLD];
  logic             take;

  op_e              op_q;

  assign fld_top  = in_word[WORD_W-1 -: FLD_W];
  assign fld_n    = in_word[3*FLD_W-1 -: FLD_W];
  assign fld_m    = in_word[2*FLD_W-1 -: FLD_W];
  assign fld_x    = in_word[FLD_W-1:0];
  assign is_arith = (fld_top == {FLD_W{1'b1}});

  fpdec_arith u_arith (
    .fld_n (fld_n),
    .fld_m (fld_m),
    .fld_x (fld_x),
    .dec   (dec_a)
  );

  fpdec_sys u_sys (
    .hi_nib  (fld_top),
    .lo_byte (in_word[2*FLD_W-1:0]),
    .dec     (dec_s)
  );

  assign dec_c  = is_arith ? dec_a : dec_s;
  assign wide_c = (dec_c.prec_dep & mode_prec) | (dec_c.size_dep & mode_size);

  assign fld_arr[0] = fld_n;
  assign fld_arr[1] = fld_m;
  assign ext_arr[0] = dec_c.ext_n & mode_size;
  assign ext_arr[1] = dec_c.ext_m & mode_size;

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_idx
    fpdec_index u_idx (
      .fld      (fld_arr[g]),
      .bank     (mode_bank),
      .pair_ext (ext_arr[g]),
      .eff      (eff_arr[g])
    );
  end

  always_comb begin
    flip_c = '0;
    if (dec_c.flip_en) begin
      unique case (dec_c.flip_sel)
        FLIP_SIZE: flip_c[SIZE_POS] = 1'b1;
        FLIP_PREC: flip_c[PREC_POS] = 1'b1;
        FLIP_BANK: flip_c[BANK_POS] = 1'b1;
        default:   flip_c = '0;
      endcase
    end
  end

  // single output stage with pass-through ready
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      op_q      <= OP_NOP;
      rn        <= '0;
      rm        <= '0;
      fn_sel    <= '0;
      fm_sel    <= '0;
      wide      <= 1'b0;
      xr_sel    <= 1'b0;
      tbit_we   <= 1'b0;
      tbit_gt   <= 1'b0;
      mode_flip <= '0;
      illegal   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      op_q      <= dec_c.op;
      rn        <= fld_n;
      rm        <= fld_m;
      fn_sel    <= eff_arr[0];
      fm_sel    <= eff_arr[1];
      wide      <= wide_c;
      xr_sel    <= dec_c.xr_sel;
      tbit_we   <= dec_c.tbit_we;
      tbit_gt   <= dec_c.tbit_gt;
      mode_flip <= flip_c;
      illegal   <= dec_c.ill;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign op = op_q;

  // R2
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(op_q) && $stable(rn) &&
    $stable(rm) && $stable(fn_sel) && $stable(fm_sel) && $stable(mode_flip) &&
    $stable(illegal));

  // R7
  illegal_is_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> op_q == OP_NOP && !tbit_we && !wide && !xr_sel &&
    mode_flip == '0);

  // R5
  flip_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(mode_flip));

  // R5
  flip_only_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_flip != '0 |-> op_q == OP_MODE_FLIP);

  // R8
  tbit_cmp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (tbit_we || tbit_gt) |-> op_q inside {OP_CMP_EQ, OP_CMP_GT});

  // R6
  xr_sys_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && xr_sel |->
    op_q inside {OP_SYS_TO_R, OP_R_TO_SYS, OP_SYS_ST_DEC, OP_SYS_LD_INC});

endmodule

// File: tb/test_fpu_op_decode.sv
module test_fpu_op_decode;
  import fpu_dec_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        mode_size = 1'b0, mode_prec = 1'b0, mode_bank = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [5:0]  op;
  logic [3:0]  rn, rm;
  logic [4:0]  fn_sel, fm_sel;
  logic        wide, xr_sel, tbit_we, tbit_gt, illegal;
  logic [21:0] mode_flip;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  fpu_op_decode i_fpu_op_decode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .mode_size(mode_size), .mode_prec(mode_prec),
    .mode_bank(mode_bank), .out_valid(out_valid), .out_ready(out_ready),
    .op(op), .rn(rn), .rm(rm), .fn_sel(fn_sel), .fm_sel(fm_sel),
    .wide(wide), .xr_sel(xr_sel), .tbit_we(tbit_we), .tbit_gt(tbit_gt),
    .mode_flip(mode_flip), .illegal(illegal)
  );

  // mode = {bank, prec, size}; flip = {bit21, bit20, bit19}
  typedef struct packed {
    logic [15:0] word;
    logic [2:0]  mode;
    op_e         xop;
    logic        ill;
    logic        wd;
    logic [4:0]  fn;
    logic [4:0]  fm;
    logic        xr;
    logic        twe;
    logic        tgt;
    logic [2:0]  flip;
  } vec_t;

  localparam int N_VEC = 53;
  localparam vec_t VT [N_VEC] = '{
    '{16'hF120, 3'b000, OP_ADD,       1'b0, 1'b0, 5'h01, 5'h02, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF341, 3'b100, OP_SUB,       1'b0, 1'b0, 5'h13, 5'h14, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF562, 3'b010, OP_MUL,       1'b0, 1'b1, 5'h05, 5'h06, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF783, 3'b011, OP_DIV,       1'b0, 1'b1, 5'h07, 5'h08, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hFAB4, 3'b000, OP_CMP_EQ,    1'b0, 1'b0, 5'h0A, 5'h0B, 1'b0, 1'b1, 1'b0, 3'b000},
    '{16'hFAB5, 3'b010, OP_CMP_GT,    1'b0, 1'b1, 5'h0A, 5'h0B, 1'b0, 1'b1, 1'b1, 3'b000},
    '{16'hF356, 3'b001, OP_LD_IDX,    1'b0, 1'b1, 5'h12, 5'h05, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF357, 3'b001, OP_ST_IDX,    1'b0, 1'b1, 5'h03, 5'h14, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF358, 3'b000, OP_LD_IND,    1'b0, 1'b0, 5'h03, 5'h05, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF479, 3'b101, OP_LD_INC,    1'b0, 1'b1, 5'h14, 5'h17, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF47A, 3'b101, OP_ST_IND,    1'b0, 1'b1, 5'h14, 5'h06, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF47B, 3'b000, OP_ST_DEC,    1'b0, 1'b0, 5'h04, 5'h07, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF35C, 3'b001, OP_MOV_RR,    1'b0, 1'b1, 5'h12, 5'h14, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF24C, 3'b001, OP_MOV_RR,    1'b0, 1'b1, 5'h02, 5'h04, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF35C, 3'b100, OP_MOV_RR,    1'b0, 1'b0, 5'h13, 5'h15, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF12E, 3'b010, OP_MAC,       1'b0, 1'b0, 5'h01, 5'h02, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF12F, 3'b011, OP_NOP,       1'b1, 1'b0, 5'h01, 5'h02, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF60D, 3'b000, OP_FROM_XR,   1'b0, 1'b0, 5'h06, 5'h00, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF61D, 3'b000, OP_TO_XR,     1'b0, 1'b0, 5'h06, 5'h01, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF62D, 3'b010, OP_ITOF,      1'b0, 1'b1, 5'h06, 5'h02, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF63D, 3'b000, OP_FTOI,      1'b0, 1'b0, 5'h06, 5'h03, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF64D, 3'b010, OP_NEG,       1'b0, 1'b0, 5'h06, 5'h04, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF65D, 3'b000, OP_ABS,       1'b0, 1'b0, 5'h06, 5'h05, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF66D, 3'b000, OP_SQRT,      1'b0, 1'b0, 5'h06, 5'h06, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF67D, 3'b000, OP_RSQRT,     1'b0, 1'b0, 5'h06, 5'h07, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF68D, 3'b000, OP_LD_ZERO,   1'b0, 1'b0, 5'h06, 5'h08, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF69D, 3'b000, OP_LD_ONE,    1'b0, 1'b0, 5'h06, 5'h09, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF6AD, 3'b000, OP_S2D,       1'b0, 1'b0, 5'h06, 5'h0A, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF6BD, 3'b000, OP_D2S,       1'b0, 1'b0, 5'h06, 5'h0B, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF6CD, 3'b000, OP_NOP,       1'b1, 1'b0, 5'h06, 5'h0C, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF6DD, 3'b000, OP_NOP,       1'b1, 1'b0, 5'h06, 5'h0D, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF6ED, 3'b000, OP_IPROD,     1'b0, 1'b0, 5'h06, 5'h0E, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF3FD, 3'b000, OP_MODE_FLIP, 1'b0, 1'b0, 5'h03, 5'h0F, 1'b0, 1'b0, 1'b0, 3'b010},
    '{16'hF7FD, 3'b000, OP_MODE_FLIP, 1'b0, 1'b0, 5'h07, 5'h0F, 1'b0, 1'b0, 1'b0, 3'b001},
    '{16'hFBFD, 3'b000, OP_MODE_FLIP, 1'b0, 1'b0, 5'h0B, 5'h0F, 1'b0, 1'b0, 1'b0, 3'b100},
    '{16'hFFFD, 3'b000, OP_MODE_FLIP, 1'b0, 1'b0, 5'h0F, 5'h0F, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF1FD, 3'b000, OP_MTRANS,    1'b0, 1'b0, 5'h01, 5'h0F, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF5FD, 3'b000, OP_MTRANS,    1'b0, 1'b0, 5'h05, 5'h0F, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF0FD, 3'b000, OP_SINCOS,    1'b0, 1'b0, 5'h00, 5'h0F, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hF2FD, 3'b000, OP_SINCOS,    1'b0, 1'b0, 5'h02, 5'h0F, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'h035A, 3'b000, OP_SYS_TO_R,  1'b0, 1'b0, 5'h03, 5'h05, 1'b1, 1'b0, 1'b0, 3'b000},
    '{16'h036A, 3'b000, OP_SYS_TO_R,  1'b0, 1'b0, 5'h03, 5'h06, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'h485A, 3'b000, OP_R_TO_SYS,  1'b0, 1'b0, 5'h08, 5'h05, 1'b1, 1'b0, 1'b0, 3'b000},
    '{16'h486A, 3'b000, OP_R_TO_SYS,  1'b0, 1'b0, 5'h08, 5'h06, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'h4252, 3'b000, OP_SYS_ST_DEC,1'b0, 1'b0, 5'h02, 5'h05, 1'b1, 1'b0, 1'b0, 3'b000},
    '{16'h4262, 3'b000, OP_SYS_ST_DEC,1'b0, 1'b0, 5'h02, 5'h06, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'h4956, 3'b000, OP_SYS_LD_INC,1'b0, 1'b0, 5'h09, 5'h05, 1'b1, 1'b0, 1'b0, 3'b000},
    '{16'h4966, 3'b000, OP_SYS_LD_INC,1'b0, 1'b0, 5'h09, 5'h06, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'h035B, 3'b000, OP_NOP,       1'b1, 1'b0, 5'h03, 5'h05, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'h135A, 3'b000, OP_NOP,       1'b1, 1'b0, 5'h03, 5'h05, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'h407A, 3'b000, OP_NOP,       1'b1, 1'b0, 5'h00, 5'h07, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'hE05A, 3'b000, OP_NOP,       1'b1, 1'b0, 5'h00, 5'h05, 1'b0, 1'b0, 1'b0, 3'b000},
    '{16'h035A, 3'b100, OP_SYS_TO_R,  1'b0, 1'b0, 5'h13, 5'h15, 1'b1, 1'b0, 1'b0, 3'b000}
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic [2:0] md, input logic rdy);
    @(negedge clk);
    in_word   = w;
    {mode_bank, mode_prec, mode_size} = md;
    in_valid  = 1'b1;
    out_ready = rdy;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  function automatic string op_tag(input logic [15:0] w);
    if (w[15:12] != 4'hF) return "R6";
    if (w[3:0] == 4'hD && w[7:4] == 4'hF) return "R5";
    if (w[3:0] == 4'hD) return "R4";
    return "R3";
  endfunction

  task automatic check_vec(input vec_t v);
    logic [21:0] exp_flip;
    exp_flip = '0;
    exp_flip[21] = v.flip[2];
    exp_flip[20] = v.flip[1];
    exp_flip[19] = v.flip[0];
    chk("R2",  "out_valid", 32'(out_valid), 32'd1);
    chk(op_tag(v.word), "op", 32'(op), 32'(v.xop));
    chk("R7",  "illegal", 32'(illegal), 32'(v.ill));
    chk("R9",  "wide", 32'(wide), 32'(v.wd));
    chk("R10", "fn_sel", 32'(fn_sel), 32'(v.fn));
    chk("R10", "fm_sel", 32'(fm_sel), 32'(v.fm));
    chk("R11", "rn", 32'(rn), 32'(v.word[11:8]));
    chk("R11", "rm", 32'(rm), 32'(v.word[7:4]));
    chk("R6",  "xr_sel", 32'(xr_sel), 32'(v.xr));
    chk("R8",  "tbit_we", 32'(tbit_we), 32'(v.twe));
    chk("R8",  "tbit_gt", 32'(tbit_gt), 32'(v.tgt));
    chk("R5",  "mode_flip", 32'(mode_flip), 32'(exp_flip));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);

    // vector table walk
    for (int i = 0; i < N_VEC; i++) begin
      send(VT[i].word, VT[i].mode, 1'b1);
      check_vec(VT[i]);
    end

    // R2: drain, then stall with a second word waiting
    @(negedge clk);
    chk("R2", "out_valid drains", 32'(out_valid), 32'd0);
    send(16'hF120, 3'b000, 1'b0);
    chk("R2", "stalled valid", 32'(out_valid), 32'd1);
    chk("R2", "in_ready low on stall", 32'(in_ready), 32'd0);
    in_word  = 16'hFAB5;
    mode_prec = 1'b1;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "op held under stall", 32'(op), 32'(OP_ADD));
    chk("R2", "fm held under stall", 32'(fm_sel), 32'h02);
    chk("R2", "tbit held under stall", 32'(tbit_we), 32'd0);
    out_ready = 1'b1;
    #0;
    chk("R2", "in_ready follows out_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "waiting compare taken", 32'(op), 32'(OP_CMP_GT));
    chk("R8", "waiting compare tbit_gt", 32'(tbit_gt), 32'd1);
    chk("R9", "waiting compare wide", 32'(wide), 32'd1);
    @(negedge clk);
    chk("R2", "out_valid drops", 32'(out_valid), 32'd0);

    // R1: reset in the middle of traffic clears the output
    send(16'hF3FD, 3'b000, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "reset clears valid", 32'(out_valid), 32'd0);
    chk("R1", "reset clears flip", 32'(mode_flip), 32'd0);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule